// File: doc/BRIEF.md
# Serial Programming Pulse Sequencer

This block is the host end of a two-wire serial programming link: one clock line and one data line. When it accepts a go strobe, it sends a frame that starts with a 4-bit command and continues with a 16-bit payload. It sends each field least-significant bit first. The data line changes only while the clock is low, so the far end samples each bit on the rising clock edge. Every serial half-period lasts a fixed, parameterised number of system cycles.

The command value 1111 starts a programming operation and gets special treatment. After its payload, the block sends a four-clock idle command with all data bits at zero. The fourth clock of that idle command rises as usual, but the block holds it high for a programmable number of cycles; this high time is what sets the length of the programming operation at the far end. The block then drives the clock low and holds it there for a second programmable count, which gives the memory array time to discharge. Only after that does the block lower its busy flag.

Two cycle-count registers hold the lengths of the high hold and of the discharge. Each register is written from one shared value bus by its own load strobe. A frame copies both registers at the moment its go strobe is accepted. Any later load therefore changes only the frames that come after.

Top module: `prog_pulse_seq`

## Requirements
- R1: After reset, and whenever the block is idle, `sclk`, `sdat` and `busy` are low.
- R2: An accepted frame sends 20 clock pulses: the 4 command bits, then the 16 payload bits, each field least-significant bit first. Bit values are valid at the rising clock edge.
- R3: Every ordinary pulse is low for HALF cycles and then high for HALF cycles. `sdat` never changes while `sclk` stays high.
- R4: `busy` rises in the cycle after a `go` that arrives while the block is idle. For an ordinary command it stays high for exactly 40*HALF cycles.
- R5: When the command is 4'b1111, four more pulses with data 0 follow the payload. The fourth of these stays high for the hold count in cycles.
- R6: After the stretched pulse falls, `sclk` stays low and `busy` stays high for the discharge count in cycles. Then `busy` falls.
- R7: A frame with command 1111 keeps `busy` high for exactly 47*HALF + hold + discharge cycles.
- R8: A `go` that arrives while `busy` is high is ignored: it adds no pulses and does not change the running frame.
- R9: `ld_hold` and `ld_dis` load `ld_val` into the hold and discharge registers. A frame uses the values held when its `go` was accepted, so a load in the same cycle as `go` affects only the next frame.
- R10: A hold or discharge count of zero acts as one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Frame start strobe |
| cmd | input | 4 | Command nibble |
| payload | input | 16 | Payload word |
| ld_hold | input | 1 | Load strobe for the hold count |
| ld_dis | input | 1 | Load strobe for the discharge count |
| ld_val | input | CW | Value for either count register |
| sclk | output | 1 | Serial clock line |
| sdat | output | 1 | Serial data line |
| busy | output | 1 | High from an accepted go until the frame ends |

## Verification
Two operations can land on the same clock edge: a write to a count register and the copy of that register taken when a frame is accepted. The bench raises `ld_hold` with a new value in the same cycle as `go`. It then expects the stretched pulse of that frame to use the old count and the next frame to use the new one. A second collision puts a `go` into a running frame, once during the bit shifting and once during the discharge. The scoreboard must then see no extra pulse, and the busy length must stay the same.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;

  localparam logic [3:0] CMD_START = 4'b1111;
  localparam int unsigned ORD_BITS   = 20;
  localparam int unsigned START_BITS = 24;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_HOLD,
    ST_DISCH
  } seq_state_e;

  // Counter preload for a span of n cycles; zero is stretched to one.
  function automatic logic [31:0] span_to_load(input logic [31:0] n);
    return (n == 32'd0) ? 32'd0 : n - 32'd1;
  endfunction

  // Index of the last serial bit of a frame.
  function automatic logic [4:0] last_index(input logic is_start);
    return is_start ? 5'(START_BITS - 1) : 5'(ORD_BITS - 1);
  endfunction

endpackage

// File: rtl/prog_phase_timer.sv
module prog_phase_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  assign zero = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load)   cnt_q <= load_val;
    else if (!zero)  cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/prog_bit_shifter.sv
module prog_bit_shifter #(
  parameter int unsigned N = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [N-1:0] load_vec,
  input  logic         advance,
  input  logic         clear,
  output logic         lsb
);
  logic [N-1:0] vec_q;

  assign lsb = vec_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        vec_q <= '0;
    else if (load)     vec_q <= load_vec;
    else if (advance)  vec_q <= vec_q >> 1;
    else if (clear)    vec_q <= '0;
  end
endmodule

// File: rtl/prog_len_regs.sv
module prog_len_regs #(
  parameter int unsigned CW       = 16,
  parameter int unsigned HOLD_RST = 40,
  parameter int unsigned DIS_RST  = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_hold,
  input  logic          ld_dis,
  input  logic [CW-1:0] ld_val,
  input  logic          capture,
  output logic [CW-1:0] hold_snap,
  output logic [CW-1:0] dis_snap
);
  logic [CW-1:0] hold_q, dis_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= CW'(HOLD_RST);
      dis_q  <= CW'(DIS_RST);
    end else begin
      if (ld_hold) hold_q <= ld_val;
      if (ld_dis)  dis_q  <= ld_val;
    end
  end

  // Snapshot takes the value held before any load on the same edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_snap <= CW'(HOLD_RST);
      dis_snap  <= CW'(DIS_RST);
    end else if (capture) begin
      hold_snap <= hold_q;
      dis_snap  <= dis_q;
    end
  end
endmodule

// File: rtl/prog_pulse_seq.sv
module prog_pulse_seq
  import prog_seq_pkg::*;
#(
  parameter int unsigned CW       = 16,
  parameter int unsigned HALF     = 2,
  parameter int unsigned HOLD_RST = 40,
  parameter int unsigned DIS_RST  = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [3:0]    cmd,
  input  logic [15:0]   payload,
  input  logic          ld_hold,
  input  logic          ld_dis,
  input  logic [CW-1:0] ld_val,
  output logic          sclk,
  output logic          sdat,
  output logic          busy
);
  localparam logic [CW-1:0] HALF_LOAD = CW'(HALF - 1);

  seq_state_e    state_q;
  logic          is_start_q;
  logic [4:0]    bit_idx_q;
  logic          hi_phase_q;
  logic          sclk_q;
  logic          busy_q;

  logic          tmr_zero, tmr_load;
  logic [CW-1:0] tmr_val;
  logic [CW-1:0] hold_snap, dis_snap;
  logic [31:0]   hold_ld32, dis_ld32;

  // Named internal events, also observed by the checker.
  logic accept_go, ev_low_end, ev_high_end, ev_hold_enter;
  logic ev_hold_end, ev_dis_end, ev_frame_done, step_next, last_bit;
  logic hold_active, dis_active;

  assign accept_go     = go && (state_q == ST_IDLE);
  assign last_bit      = (bit_idx_q == last_index(is_start_q));
  assign ev_low_end    = (state_q == ST_SHIFT) && !hi_phase_q && tmr_zero;
  assign ev_high_end   = (state_q == ST_SHIFT) &&  hi_phase_q && tmr_zero;
  assign ev_hold_enter = ev_low_end && is_start_q && last_bit;
  assign ev_hold_end   = (state_q == ST_HOLD)  && tmr_zero;
  assign ev_dis_end    = (state_q == ST_DISCH) && tmr_zero;
  assign step_next     = ev_high_end && !last_bit;
  assign ev_frame_done = (ev_high_end && last_bit) || ev_dis_end;
  assign hold_active   = (state_q == ST_HOLD);
  assign dis_active    = (state_q == ST_DISCH);

  assign hold_ld32 = span_to_load(32'(hold_snap));
  assign dis_ld32  = span_to_load(32'(dis_snap));

  always_comb begin
    tmr_load = accept_go || ev_low_end || step_next || ev_hold_end;
    if (ev_hold_enter)    tmr_val = hold_ld32[CW-1:0];
    else if (ev_hold_end) tmr_val = dis_ld32[CW-1:0];
    else                  tmr_val = HALF_LOAD;
  end

  prog_phase_timer #(.W(CW)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  prog_bit_shifter #(.N(START_BITS)) shifter_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept_go),
    .load_vec ({4'h0, payload, cmd}),
    .advance  (step_next),
    .clear    (ev_frame_done),
    .lsb      (sdat)
  );

  prog_len_regs #(
    .CW       (CW),
    .HOLD_RST (HOLD_RST),
    .DIS_RST  (DIS_RST)
  ) lens_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_hold   (ld_hold),
    .ld_dis    (ld_dis),
    .ld_val    (ld_val),
    .capture   (accept_go),
    .hold_snap (hold_snap),
    .dis_snap  (dis_snap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      is_start_q <= 1'b0;
      bit_idx_q  <= '0;
      hi_phase_q <= 1'b0;
      sclk_q     <= 1'b0;
      busy_q     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept_go) begin
          state_q    <= ST_SHIFT;
          is_start_q <= (cmd == CMD_START);
          bit_idx_q  <= '0;
          hi_phase_q <= 1'b0;
          sclk_q     <= 1'b0;
          busy_q     <= 1'b1;
        end
        ST_SHIFT: if (tmr_zero) begin
          if (!hi_phase_q) begin
            sclk_q <= 1'b1;
            if (ev_hold_enter) state_q    <= ST_HOLD;
            else               hi_phase_q <= 1'b1;
          end else begin
            sclk_q     <= 1'b0;
            hi_phase_q <= 1'b0;
            if (last_bit) begin
              state_q <= ST_IDLE;
              busy_q  <= 1'b0;
            end else begin
              bit_idx_q <= bit_idx_q + 5'd1;
            end
          end
        end
        ST_HOLD: if (tmr_zero) begin
          sclk_q  <= 1'b0;
          state_q <= ST_DISCH;
        end
        ST_DISCH: if (tmr_zero) begin
          state_q <= ST_IDLE;
          busy_q  <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sclk = sclk_q;
  assign busy = busy_q;

endmodule

// File: rtl/prog_pulse_seq_chk.sv
module prog_pulse_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic go,
  input logic sclk,
  input logic sdat,
  input logic busy,
  input logic hold_active,
  input logic dis_active
);
  a_r3_data_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdat));

  a_r1_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);

  a_r4_go_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !busy) |=> busy);

  a_r5_hold_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active |-> (sclk && busy));

  a_r6_discharge_low: assert property (@(posedge clk) disable iff (!rst_n)
    dis_active |-> (!sclk && busy));

  a_r6_busy_ends_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !sclk);
endmodule

bind prog_pulse_seq prog_pulse_seq_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .go          (go),
  .sclk        (sclk),
  .sdat        (sdat),
  .busy        (busy),
  .hold_active (hold_active),
  .dis_active  (dis_active)
);

// File: tb/prog_pulse_seq_tb_top.sv
`timescale 1ns/1ps
module prog_pulse_seq_tb_top;
  localparam int H  = 2;
  localparam int CW = 16;
  localparam int HR = 40;
  localparam int DR = 12;

  logic clk = 1'b0, rst_n = 1'b0, go = 1'b0, ld_hold = 1'b0, ld_dis = 1'b0;
  logic [3:0] cmd = '0;
  logic [15:0] payload = '0;
  logic [CW-1:0] ld_val = '0;
  logic sclk, sdat, busy;

  always #2 clk = ~clk;

  prog_pulse_seq #(.CW(CW), .HALF(H), .HOLD_RST(HR), .DIS_RST(DR)) dut_i (
    .clk(clk), .rst_n(rst_n), .go(go), .cmd(cmd), .payload(payload),
    .ld_hold(ld_hold), .ld_dis(ld_dis), .ld_val(ld_val),
    .sclk(sclk), .sdat(sdat), .busy(busy)
  );

  typedef struct { bit b; int hi; int dis; } exp_t;
  exp_t exq[$];
  int n_chk = 0, n_fail = 0;
  int tb_hold = HR, tb_dis = DR;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Monitor: pops one expected item per rising sclk.
  initial begin
    bit prev_s = 0, have = 0, dis_mode = 0;
    int hi_cnt = 0, dis_cnt = 0, dis_exp = 0;
    exp_t cur;
    cur = '{b: 0, hi: 0, dis: -1};
    forever begin
      @(negedge clk);
      if (!rst_n) begin prev_s = 0; have = 0; dis_mode = 0; continue; end
      if (dis_mode) begin
        if (busy && !sclk) dis_cnt++;
        else begin
          chk(dis_cnt == dis_exp, "R6", "discharge length", dis_cnt, dis_exp);
          dis_mode = 0;
        end
      end
      if (sclk && !prev_s) begin
        if (exq.size() == 0) chk(0, "R8", "unexpected clock pulse", 1, 0);
        else begin
          cur = exq.pop_front();
          have = 1;
          chk(sdat == cur.b, "R2", "data bit at rising edge", int'(sdat), int'(cur.b));
        end
        hi_cnt = 1;
      end else if (sclk) begin
        hi_cnt++;
      end else if (prev_s && have) begin
        chk(hi_cnt == cur.hi, (cur.dis >= 0) ? "R5" : "R3", "high width", hi_cnt, cur.hi);
        if (cur.dis >= 0) begin dis_mode = 1; dis_cnt = 1; dis_exp = cur.dis; end
        have = 0;
      end
      prev_s = sclk;
    end
  end

  // Driver: pushes the expected pulses, starts the frame, times busy.
  task automatic send(input logic [3:0] c, input logic [15:0] p,
                      input bit ld_same, input logic [CW-1:0] v);
    bit st = (c == 4'hF);
    int l_eff = (tb_hold == 0) ? 1 : tb_hold;
    int d_eff = (tb_dis == 0) ? 1 : tb_dis;
    int exp_busy = st ? (47*H + l_eff + d_eff) : 40*H;
    int cnt = 0;
    for (int i = 0; i < 4; i++)  exq.push_back('{b: c[i], hi: H, dis: -1});
    for (int i = 0; i < 16; i++) exq.push_back('{b: p[i], hi: H, dis: -1});
    if (st) begin
      for (int i = 0; i < 3; i++) exq.push_back('{b: 1'b0, hi: H, dis: -1});
      exq.push_back('{b: 1'b0, hi: l_eff, dis: d_eff});
    end
    @(negedge clk);
    go = 1; cmd = c; payload = p;
    if (ld_same) begin ld_hold = 1; ld_val = v; end
    @(negedge clk);
    go = 0; ld_hold = 0;
    if (ld_same) tb_hold = int'(v);
    while (busy) begin cnt++; @(negedge clk); end
    chk(cnt == exp_busy, st ? "R7" : "R4", "busy length", cnt, exp_busy);
    chk(exq.size() == 0, "R2", "pulses left unsent", exq.size(), 0);
    chk(!sclk && !sdat, "R1", "lines low when idle", int'({sclk, sdat}), 0);
  endtask

  task automatic load_reg(input bit is_hold, input logic [CW-1:0] v);
    @(negedge clk);
    if (is_hold) ld_hold = 1; else ld_dis = 1;
    ld_val = v;
    @(negedge clk);
    ld_hold = 0; ld_dis = 0;
    if (is_hold) tb_hold = int'(v); else tb_dis = int'(v);
  endtask

  task automatic stray_go(input int wait_cyc);
    repeat (wait_cyc) @(negedge clk);
    go = 1; cmd = 4'h3; payload = 16'hFFFF;
    @(negedge clk);
    go = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!sclk && !sdat && !busy, "R1", "reset outputs", int'({sclk, sdat, busy}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!sclk && !busy, "R1", "idle after reset", int'({sclk, busy}), 0);

    // Ordinary frames (R2, R3, R4)
    send(4'h0, 16'h1234, 0, '0);
    send(4'hD, 16'hA5C3, 0, '0);
    send(4'h2, 16'hFFFF, 0, '0);
    send(4'h9, 16'h0001, 0, '0);

    // Start-programming frames (R5, R6, R7) with reset counts, then loaded
    send(4'hF, 16'hBEEF, 0, '0);
    load_reg(1, 16'd7);
    load_reg(0, 16'd3);
    send(4'hF, 16'h0F0F, 0, '0);

    // R9: load coinciding with go uses old value now, new value next frame
    send(4'hF, 16'h5555, 1, 16'd9);
    send(4'hF, 16'h1111, 0, '0);

    // R10: zero counts behave as one cycle
    load_reg(1, 16'd0);
    load_reg(0, 16'd0);
    send(4'hF, 16'h8001, 0, '0);

    // R8: go during shifting and during discharge is ignored
    load_reg(1, 16'd5);
    load_reg(0, 16'd10);
    fork
      send(4'h6, 16'h3C3C, 0, '0);
      stray_go(30);
    join
    fork
      send(4'hF, 16'h7E7E, 0, '0);
      stray_go(104);
    join
    repeat (4) @(negedge clk);
    chk(!busy, "R8", "no frame started by ignored go", int'(busy), 0);

    summary();
  end
endmodule